// File: doc/BRIEF.md
# Bridge interrupt aggregator

This block collects eleven interrupt request lines from devices below a bus bridge and turns activity on them into a single message-style interrupt toward a host. Each line passes through a two-flop synchronizer. The block watches every line for a change of state in either direction. A change on an enabled line is captured into a read-to-clear request register. The same change starts one outbound write that carries a programmed data word to a programmed address. Changes on every implemented line, enabled or not, are also captured in a separate read-to-clear pending register. A live level register shows the synchronized state of each line at all times, so software can run a level-sensitive sharing scheme on top of change-triggered messages.

Software reaches the block through a small register port. Writes take effect at the clock edge. Read data is combinational in the cycle that `reg_rd` is high, and the read-to-clear side effect happens at that same edge. Offsets:
- 0: mask.
- 1: pending.
- 2: request.
- 3: live level.
- 4: target.
- 5: retrigger. Writing it sends a message without any line activity.

The message leaves on a valid/ready stream. Once `msg_valid` is high, `msg_addr` and `msg_data` hold still until a cycle in which `msg_ready` is also high. The stream is free to wait any number of cycles. Only one message is outstanding at a time. Any number of events that arrive while a message waits fold into one further message, which is launched in the cycle the waiting one is accepted.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset, the following values hold:
  - The mask, pending and target registers read 0.
  - `msg_valid` is 0.
  - The request register reads back its stale reset contents `0x5FF`. The first read clears them, so a second read returns 0.
- R2: The mask register at offset 0 stores one enable bit per line in bits 10:0. A write of all ones reads back `0x7FF`.
- R3: A rising or falling change on line i, with mask bit i set, does two things:
  - It sets request bit i.
  - It raises `msg_valid` after the third rising clock edge following the change, counting the edge that first samples it.
- R4: A change on a line whose mask bit is clear does three things:
  - It leaves the request bit clear.
  - It sends no message.
  - It still sets that line's pending bit (offset 1, bit i).
- R5: The request register (offset 2) follows these rules:
  - It reports only implemented lines, mask `0x5FF`. Line 9 is never captured and never sends a message.
  - A read returns the captured bits and clears them.
- R6: A read of the pending register returns its bits and clears them. The read changes neither the live level register nor the request register.
- R7: The live level register (offset 3, bits 10:0) shows the synchronized state of all eleven lines. The view is independent of the mask and of any capture.
- R8: Setting a mask bit while its line is already asserted sends no message and sets no request bit. A later change on that line does send a message.
- R9: The target register is at offset 4. Each message carries:
  - `msg_addr`: the target word with bits 4:0 cleared.
  - `msg_data`: target bits 4:0.
- R10: The outbound message obeys these handshake rules:
  - While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
  - Events that arrive meanwhile, however many, produce exactly one more message after acceptance. That message uses the target value current at its launch.
- R11: A write to offset 5 raises `msg_valid` after that write's clock edge.
- R12: A change captured in the same cycle as a read of the request register is kept. The read returns the old contents, and the new bit appears on the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 11 | Raw interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-to-clear side effects) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| msg_valid | output | 1 | Outbound interrupt message valid |
| msg_ready | input | 1 | Outbound interrupt message accepted |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 5 | Message data word |

## Verification
The bench drives a change into a line on the exact cycle in which the request register is being read. A design that lets the clear win would drop that interrupt for good.

The bench also covers these corner cases:
- **Stalled message stream.** The bench holds the stream stalled while further changes arrive and the target is rewritten. A design that overwrote the waiting message, lost the folded event, or sent two messages would show up in the address checks and in the valid checks.
- **Unmasking an asserted line.** A design that treated the enable as a level would fire a spurious message here.
- **Unimplemented line 9.** Activity on line 9 must never reach the request register or the message stream.
- **Read side effects.** A pending read must leave the live level register and the request register untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Register offsets on the software port
  typedef enum logic [2:0] {
    OFS_MASK   = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_REQ    = 3'd2,
    OFS_LEVEL  = 3'd3,
    OFS_TARGET = 3'd4,
    OFS_KICK   = 3'd5
  } reg_ofs_e;

  localparam int unsigned OFS_W = 3;
endpackage

// File: rtl/irq_sync_edge.sv
// Two-flop synchronizer per line plus a history flop for change detection.
module irq_sync_edge #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_in,
  output logic [N-1:0] level,
  output logic [N-1:0] toggled
);
  logic [N-1:0] meta_q, sync_q, hist_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        hist_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= lines_in[i];
        sync_q[i] <= meta_q[i];
        hist_q[i] <= sync_q[i];
      end
    end
    assign toggled[i] = sync_q[i] ^ hist_q[i];
  end

  assign level = sync_q;
endmodule

// File: rtl/irq_capture.sv
// Sticky capture vector: new sets win over a clear in the same cycle.
module irq_capture #(
  parameter int unsigned    N    = 11,
  parameter logic [N-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] bits
);
  logic [N-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= INIT;
    else        bits_q <= (clr ? '0 : bits_q) | set_vec;
  end

  assign bits = bits_q;
endmodule

// File: rtl/irq_msg_launch.sv
// Single-outstanding message source with one folded follow-up.
module irq_msg_launch #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          event_i,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  logic          valid_q, owed_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          fire, launch;

  assign fire   = valid_q && msg_ready;
  assign launch = (!valid_q || fire) && (event_i || (fire && owed_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      owed_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (launch) begin
        valid_q <= 1'b1;
        owed_q  <= 1'b0;
        addr_q  <= tgt_addr;
        data_q  <= tgt_data;
      end else begin
        if (fire) valid_q <= 1'b0;
        owed_q <= owed_q | event_i;
      end
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
  parameter int unsigned            NUM_LINES     = 11,
  parameter logic [NUM_LINES-1:0]   IMPL_MASK     = 11'h5FF,
  parameter logic [NUM_LINES-1:0]   REQ_INIT      = 11'h7FF,
  parameter int unsigned            REG_W         = 32,
  parameter int unsigned            MSG_DATA_BITS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_LINES-1:0]     irq_in,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [2:0]               reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [REG_W-1:0]         msg_addr,
  output logic [MSG_DATA_BITS-1:0] msg_data
);
  import irq_agg_pkg::*;

  localparam int unsigned PAD_W = REG_W - NUM_LINES;

  logic [NUM_LINES-1:0] lvl, toggled, en_edges, all_edges;
  logic [NUM_LINES-1:0] req_bits, pend_bits, mask_q;
  logic [REG_W-1:0]     target_q;
  logic                 rd_req, rd_pend, kick, evt;

  irq_sync_edge #(.N(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_in(irq_in),
    .level(lvl), .toggled(toggled)
  );

  assign all_edges = toggled & IMPL_MASK;
  assign en_edges  = all_edges & mask_q;

  assign rd_req  = reg_rd && (reg_addr == OFS_REQ);
  assign rd_pend = reg_rd && (reg_addr == OFS_PEND);
  assign kick    = reg_wr && (reg_addr == OFS_KICK);
  assign evt     = (|en_edges) || kick;

  irq_capture #(.N(NUM_LINES), .INIT(REQ_INIT & IMPL_MASK)) u_req (
    .clk(clk), .rst_n(rst_n), .set_vec(en_edges), .clr(rd_req), .bits(req_bits)
  );

  irq_capture #(.N(NUM_LINES), .INIT('0)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(all_edges), .clr(rd_pend), .bits(pend_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      target_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_MASK)   mask_q   <= reg_wdata[NUM_LINES-1:0];
      if (reg_addr == OFS_TARGET) target_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_MASK:   reg_rdata = {{PAD_W{1'b0}}, mask_q};
        OFS_PEND:   reg_rdata = {{PAD_W{1'b0}}, pend_bits & IMPL_MASK};
        OFS_REQ:    reg_rdata = {{PAD_W{1'b0}}, req_bits & IMPL_MASK};
        OFS_LEVEL:  reg_rdata = {{PAD_W{1'b0}}, lvl};
        OFS_TARGET: reg_rdata = target_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

  irq_msg_launch #(.AW(REG_W), .DW(MSG_DATA_BITS)) u_launch (
    .clk(clk), .rst_n(rst_n), .event_i(evt),
    .tgt_addr({target_q[REG_W-1:MSG_DATA_BITS], {MSG_DATA_BITS{1'b0}}}),
    .tgt_data(target_q[MSG_DATA_BITS-1:0]),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/irq_msg_aggregator_chk.sv
module irq_msg_aggregator_chk #(
  parameter int unsigned NUM_LINES = 11,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [AW-1:0]        msg_addr,
  input logic [DW-1:0]        msg_data,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] req_bits,
  input logic [NUM_LINES-1:0] en_edges,
  input logic                 reg_rd,
  input logic                 reg_wr,
  input logic [2:0]           reg_addr
);
  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R3
  msg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_edges) |=> msg_valid);

  // R4
  req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~mask_q)) |=> ((req_bits & ~$past(req_bits) & ~$past(mask_q)) == '0));

  // R5
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2) |=> ((req_bits & ~$past(en_edges)) == '0));

  // R12
  req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_edges) |=> ((req_bits & $past(en_edges)) == $past(en_edges)));

  // R11
  kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd5) |=> msg_valid);
endmodule

bind irq_msg_aggregator irq_msg_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .AW(REG_W), .DW(MSG_DATA_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .mask_q(mask_q),
  .req_bits(req_bits), .en_edges(en_edges), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/irq_msg_aggregator_bench.sv
`timescale 1ns/1ps
module irq_msg_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [4:0]  msg_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  irq_msg_aggregator u_irq_msg_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept_msg;
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd0, rv); check("R1 mask", rv, 32'h0);
    reg_read(3'd1, rv); check("R1 pend", rv, 32'h0);
    reg_read(3'd4, rv); check("R1 target", rv, 32'h0);
    reg_read(3'd2, rv); check("R1 stale req", rv, 32'h5FF);
    reg_read(3'd2, rv); check("R1 req cleared", rv, 32'h0);
  endtask

  task automatic t_mask_rw;
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, rv); check("R2 mask all", rv, 32'h7FF);
    reg_write(3'd0, 32'h0000_0001);
    reg_read(3'd0, rv); check("R2 mask one", rv, 32'h1);
  endtask

  task automatic t_edge_msg;
    reg_write(3'd4, 32'h8000_1237);
    @(negedge clk); irq_in[0] = 1'b1;
    wait_cyc(1); check("R3 no msg k", {31'b0, msg_valid}, 32'h0);
    wait_cyc(1); check("R3 no msg k+1", {31'b0, msg_valid}, 32'h0);
    wait_cyc(1); check("R3 msg rise", {31'b0, msg_valid}, 32'h1);
    check("R9 addr", msg_addr, 32'h8000_1220);
    check("R9 data", {27'b0, msg_data}, 32'h17);
    reg_read(3'd2, rv); check("R3 req bit0", rv, 32'h1);
    reg_read(3'd2, rv); check("R5 req clr", rv, 32'h0);
    accept_msg;
    check("R10 accepted", {31'b0, msg_valid}, 32'h0);
    @(negedge clk); irq_in[0] = 1'b0;
    wait_cyc(3); check("R3 msg fall", {31'b0, msg_valid}, 32'h1);
    accept_msg;
    reg_read(3'd2, rv); check("R3 req fall", rv, 32'h1);
  endtask

  task automatic t_masked;
    reg_read(3'd1, rv);
    @(negedge clk); irq_in[5] = 1'b1;
    wait_cyc(4);
    check("R4 no msg", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd2, rv); check("R4 no req", rv, 32'h0);
    reg_read(3'd3, rv); check("R7 level", rv, 32'h020);
    reg_read(3'd1, rv); check("R4 pend set", rv, 32'h020);
    reg_read(3'd1, rv); check("R6 pend clr", rv, 32'h0);
    reg_read(3'd3, rv); check("R6 level kept", rv, 32'h020);
    @(negedge clk); irq_in[5] = 1'b0;
    wait_cyc(4);
    reg_read(3'd1, rv);
    reg_read(3'd2, rv); check("R6 req untouched", rv, 32'h0);
  endtask

  task automatic t_unimpl;
    reg_write(3'd0, 32'h7FF);
    @(negedge clk); irq_in[9] = 1'b1;
    wait_cyc(4);
    check("R5 line9 no msg", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd2, rv); check("R5 line9 no req", rv, 32'h0);
    reg_read(3'd3, rv); check("R7 line9 level", rv, 32'h200);
    @(negedge clk); irq_in[10] = 1'b1;
    wait_cyc(4);
    reg_read(3'd2, rv); check("R5 line10 req", rv, 32'h400);
    accept_msg;
    @(negedge clk); irq_in[9] = 1'b0; irq_in[10] = 1'b0;
    wait_cyc(4);
    accept_msg;
    reg_read(3'd2, rv); reg_read(3'd1, rv);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_unmask_asserted;
    @(negedge clk); irq_in[3] = 1'b1;
    wait_cyc(4);
    reg_read(3'd1, rv); reg_read(3'd2, rv);
    reg_write(3'd0, 32'h008);
    wait_cyc(4);
    check("R8 no msg", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd2, rv); check("R8 no req", rv, 32'h0);
    @(negedge clk); irq_in[3] = 1'b0;
    wait_cyc(3); check("R8 later change", {31'b0, msg_valid}, 32'h1);
    accept_msg;
    reg_read(3'd2, rv);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_handshake;
    reg_write(3'd0, 32'h002);
    reg_write(3'd4, 32'hA000_0041);
    @(negedge clk); irq_in[1] = 1'b1;
    wait_cyc(3); check("R10 first valid", {31'b0, msg_valid}, 32'h1);
    reg_write(3'd4, 32'hB000_0062);
    @(negedge clk); irq_in[1] = 1'b0;
    wait_cyc(4);
    check("R10 held valid", {31'b0, msg_valid}, 32'h1);
    check("R10 held addr", msg_addr, 32'hA000_0040);
    check("R10 held data", {27'b0, msg_data}, 32'h01);
    accept_msg;
    check("R10 folded valid", {31'b0, msg_valid}, 32'h1);
    check("R10 folded addr", msg_addr, 32'hB000_0060);
    accept_msg;
    check("R10 single follow-up", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd2, rv);
    reg_write(3'd0, 32'h0);
  endtask

  task automatic t_kick;
    reg_write(3'd4, 32'h1234_567F);
    reg_write(3'd5, 32'h0);
    check("R11 kick valid", {31'b0, msg_valid}, 32'h1);
    check("R11 kick data", {27'b0, msg_data}, 32'h1F);
    accept_msg;
    check("R11 kick done", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_collide;
    reg_write(3'd0, 32'h004);
    reg_read(3'd2, rv);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk);
    reg_read(3'd2, rv); check("R12 old contents", rv, 32'h0);
    reg_read(3'd2, rv); check("R12 edge kept", rv, 32'h004);
    accept_msg;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask_rw;
    t_edge_msg;
    t_masked;
    reg_write(3'd0, 32'h0);
    t_unimpl;
    t_unmask_asserted;
    t_handshake;
    t_kick;
    t_collide;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule